// File: doc/BRIEF.md
# Split-Byte Three-State Output Port

This block presents a held 12-bit conversion result on a host data bus. The bus may be 12 or 16 bits wide, or only 8 bits wide. In wide mode the whole word goes out at once. In narrow mode the word is sent left-justified as two bytes. The upper byte carries the eight most significant result bits. The lower byte carries a forced-zero nibble above the four least significant result bits. A byte-address input picks which byte is shown.

Each data lane is modelled as a value plus a per-lane output enable, and the top level turns these into three-state lines. Lanes are enabled only while a read is qualified: read/convert high, converter idle, chip enable high and chip select low. Whenever the shown pattern changes from one active byte layout to another, every lane first passes through a disabled gap. The two bytes therefore never drive the bus together, however the byte-address input toggles.

The result register takes a new word only on the end-of-conversion strobe, and keeps it until the next one.

Top module: `split_byte_out_port`

## Requirements
- R1: After reset every lane is disabled and the held result is zero.
- R2: All lanes stay disabled in any cycle where `rd_cnv` is low, `busy` is high, `chip_en` is low or `chip_sel_n` is high. Losing any of these disables the lanes in the same cycle.
- R3: With `wide_sel` = 1 and a qualified read, all twelve lanes are enabled and carry the held result. `byte_addr` is ignored, and toggling it causes no gap.
- R4: With `wide_sel` = 0, `byte_addr` = 0 and a qualified read, lanes 11..4 are enabled and carry result bits 11..4. Lanes 3..0 are disabled (enable mask 12'hFF0).
- R5: With `wide_sel` = 0, `byte_addr` = 1 and a qualified read, lanes 11..8 are disabled, lanes 7..4 are driven to zero, and lanes 3..0 carry result bits 3..0 (enable mask 12'h0FF).
- R6: A change from one active lane pattern to a different one disables all lanes in the cycle of the request and for the whole following clock cycle. The new pattern appears after the second rising edge. The high-byte and low-byte patterns are never active in consecutive observations.
- R7: When a qualified read starts from the all-disabled state, the requested pattern appears after the first rising edge and not before.
- R8: The held result loads `conv_word` only on a clock edge where `conv_done` is high. At other times changes on `conv_word` do not reach the lanes.
- R9: A disabled lane shows value 0 on `lane_val`, and the enabled lanes of `data_bus` equal `lane_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | End-of-conversion strobe; loads the held result |
| conv_word | input | 12 | Conversion result from the converter |
| wide_sel | input | 1 | 1: present all 12 bits; 0: two-byte mode |
| byte_addr | input | 1 | Two-byte mode: 0 selects upper byte, 1 lower byte |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| rd_cnv | input | 1 | Read/convert; high permits reading |
| busy | input | 1 | Conversion in progress; blocks reading |
| lane_val | output | 12 | Per-lane value, zero on disabled lanes |
| lane_oe | output | 12 | Per-lane output enable |
| data_bus | output | 12 | Three-state lines resolved from value and enable |

## Verification
A wrong sequencer state shows up at the ports within one clock edge. Either a byte appears without its disabled gap, or a stale pattern stays enabled after the request has moved. The bench flags this by watching consecutive lane patterns on every cycle. A corrupted held result shows up as a wrong lane value on the very next qualified read. An exhaustive sweep over all 4096 words, in every layout, catches a misplaced nibble or a missing zero nibble at the first word that has a non-zero bit there.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [1:0] {
    PK_OFF  = 2'd0,
    PK_WIDE = 2'd1,
    PK_HI   = 2'd2,
    PK_LO   = 2'd3
  } port_kind_e;
endpackage

// File: rtl/sbp_result_hold.sv
module sbp_result_hold #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/sbp_request_decode.sv
module sbp_request_decode
  import sbp_pkg::*;
(
  input  logic       wide_sel,
  input  logic       byte_addr,
  input  logic       chip_en,
  input  logic       chip_sel_n,
  input  logic       rd_cnv,
  input  logic       busy,
  output logic       read_ok,
  output port_kind_e req_kind
);
  always_comb begin
    read_ok = rd_cnv & ~busy & chip_en & ~chip_sel_n;
    if (!read_ok)       req_kind = PK_OFF;
    else if (wide_sel)  req_kind = PK_WIDE;
    else if (byte_addr) req_kind = PK_LO;
    else                req_kind = PK_HI;
  end
endmodule

// File: rtl/sbp_bbm_sequencer.sv
module sbp_bbm_sequencer
  import sbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  port_kind_e req_kind,
  output port_kind_e drive_kind,
  output port_kind_e shown_kind,
  output logic       gap_active
);
  port_kind_e next_kind;
  logic       settled;

  always_comb begin
    settled    = (req_kind == drive_kind);
    gap_active = !settled && (drive_kind != PK_OFF) && (req_kind != PK_OFF);
    if (gap_active) next_kind = PK_OFF;
    else            next_kind = req_kind;
    shown_kind = settled ? drive_kind : PK_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_kind <= PK_OFF;
    else        drive_kind <= next_kind;
  end
endmodule

// File: rtl/sbp_lane_driver.sv
module sbp_lane_driver
  import sbp_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  port_kind_e           kind,
  input  logic [3*NIB_W-1:0]   word,
  output logic [3*NIB_W-1:0]   val,
  output logic [3*NIB_W-1:0]   oe,
  output wire  [3*NIB_W-1:0]   bus
);
  localparam int RES_W  = 3 * NIB_W;
  localparam int BYTE_W = 2 * NIB_W;

  function automatic logic [RES_W-1:0] kind_mask(port_kind_e k);
    logic [RES_W-1:0] ones;
    ones = '1;
    case (k)
      PK_WIDE: return ones;
      PK_HI:   return ones << (RES_W - BYTE_W);
      PK_LO:   return ones >> (RES_W - BYTE_W);
      default: return '0;
    endcase
  endfunction

  function automatic logic [RES_W-1:0] kind_data(port_kind_e k, logic [RES_W-1:0] w);
    logic [RES_W-1:0] low_mask;
    low_mask = {{(RES_W-NIB_W){1'b0}}, {NIB_W{1'b1}}};
    case (k)
      PK_WIDE: return w;
      PK_HI:   return (w >> NIB_W) << NIB_W;
      PK_LO:   return w & low_mask;
      default: return '0;
    endcase
  endfunction

  logic [RES_W-1:0] mask_c;
  logic [RES_W-1:0] data_c;

  always_comb begin
    mask_c = kind_mask(kind);
    data_c = kind_data(kind, word);
  end

  for (genvar i = 0; i < RES_W; i++) begin : g_lane
    assign oe[i]  = mask_c[i];
    assign val[i] = mask_c[i] & data_c[i];
    assign bus[i] = mask_c[i] ? data_c[i] : 1'bz;
  end
endmodule

// File: rtl/split_byte_out_port.sv
module split_byte_out_port
  import sbp_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int RES_W = 3 * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_word,
  input  logic             wide_sel,
  input  logic             byte_addr,
  input  logic             chip_en,
  input  logic             chip_sel_n,
  input  logic             rd_cnv,
  input  logic             busy,
  output logic [RES_W-1:0] lane_val,
  output logic [RES_W-1:0] lane_oe,
  output wire  [RES_W-1:0] data_bus
);
  logic [RES_W-1:0] result_q;
  logic             read_ok;
  port_kind_e       req_kind;
  port_kind_e       drive_kind;
  port_kind_e       shown_kind;
  logic             gap_active;

  sbp_result_hold #(.W(RES_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (conv_done),
    .d     (conv_word),
    .q     (result_q)
  );

  sbp_request_decode u_dec (
    .wide_sel   (wide_sel),
    .byte_addr  (byte_addr),
    .chip_en    (chip_en),
    .chip_sel_n (chip_sel_n),
    .rd_cnv     (rd_cnv),
    .busy       (busy),
    .read_ok    (read_ok),
    .req_kind   (req_kind)
  );

  sbp_bbm_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_kind   (req_kind),
    .drive_kind (drive_kind),
    .shown_kind (shown_kind),
    .gap_active (gap_active)
  );

  sbp_lane_driver #(.NIB_W(NIB_W)) u_lanes (
    .kind (shown_kind),
    .word (result_q),
    .val  (lane_val),
    .oe   (lane_oe),
    .bus  (data_bus)
  );
endmodule

// File: rtl/split_byte_out_port_chk.sv
module split_byte_out_port_chk
  import sbp_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int RES_W = 3 * NIB_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_done,
  input logic [RES_W-1:0] conv_word,
  input logic             rd_cnv,
  input logic             busy,
  input logic             chip_en,
  input logic             chip_sel_n,
  input logic [RES_W-1:0] lane_val,
  input logic [RES_W-1:0] lane_oe,
  input logic [RES_W-1:0] result_q,
  input logic             gap_active
);
  localparam logic [RES_W-1:0] ALL_M = '1;
  localparam logic [RES_W-1:0] HI_M  = ALL_M << NIB_W;
  localparam logic [RES_W-1:0] LO_M  = ALL_M >> NIB_W;
  localparam logic [RES_W-1:0] MID_M = HI_M & LO_M;

  logic qual, hi_on, lo_on;
  assign qual  = rd_cnv && !busy && chip_en && !chip_sel_n;
  assign hi_on = (lane_oe == HI_M);
  assign lo_on = (lane_oe == LO_M);

  a_r2_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |-> (lane_oe == '0));

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe != ALL_M) |-> !((|(lane_oe & ~LO_M)) && (|(lane_oe & ~HI_M))));

  a_r6_lo_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
    lo_on |-> !$past(hi_on));

  a_r6_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
    hi_on |-> !$past(lo_on));

  a_r6_gap_dark: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |-> (lane_oe == '0));

  a_r5_zero_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    lo_on |-> ((lane_val & MID_M) == '0));

  a_r9_off_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_val & ~lane_oe) == '0);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(result_q));

  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (result_q == $past(conv_word)));
endmodule

bind split_byte_out_port split_byte_out_port_chk #(.NIB_W(NIB_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_done  (conv_done),
  .conv_word  (conv_word),
  .rd_cnv     (rd_cnv),
  .busy       (busy),
  .chip_en    (chip_en),
  .chip_sel_n (chip_sel_n),
  .lane_val   (lane_val),
  .lane_oe    (lane_oe),
  .result_q   (result_q),
  .gap_active (gap_active)
);

// File: tb/split_byte_out_port_test.sv
module split_byte_out_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_word = '0;
  logic        wide_sel = 1'b0, byte_addr = 1'b0;
  logic        chip_en = 1'b0, chip_sel_n = 1'b1, rd_cnv = 1'b0, busy = 1'b0;
  logic [11:0] lane_val, lane_oe;
  wire  [11:0] data_bus;

  int tests = 0, fails = 0;
  int mon_viol = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  split_byte_out_port uut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_word(conv_word),
    .wide_sel(wide_sel), .byte_addr(byte_addr), .chip_en(chip_en),
    .chip_sel_n(chip_sel_n), .rd_cnv(rd_cnv), .busy(busy),
    .lane_val(lane_val), .lane_oe(lane_oe), .data_bus(data_bus)
  );

  // expected layouts, computed arithmetically
  function automatic logic [11:0] exp_hi(logic [11:0] w);
    return 12'((w / 16) * 16);
  endfunction
  function automatic logic [11:0] exp_lo(logic [11:0] w);
    return 12'(w % 16);
  endfunction

  task automatic check(string tag, logic [11:0] e_oe, logic [11:0] e_val);
    tests++;
    if (lane_oe !== e_oe || lane_val !== e_val ||
        ((data_bus & e_oe) !== (e_val & e_oe))) begin
      fails++;
      $display("FAIL %s: oe=%h val=%h bus=%h expected oe=%h val=%h",
               tag, lane_oe, lane_val, data_bus, e_oe, e_val);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic set_read(logic rc, logic bz, logic ce, logic csn, logic ws, logic ba);
    rd_cnv = rc; busy = bz; chip_en = ce; chip_sel_n = csn;
    wide_sel = ws; byte_addr = ba;
    #1;
  endtask

  task automatic load_word(logic [11:0] w);
    conv_word = w; conv_done = 1'b1;
    tick();
    conv_done = 1'b0;
  endtask

  // monitor: consecutive active patterns must be separated by a dark cycle (R6)
  initial begin
    int prev_p;
    int cur_p;
    prev_p = 0;
    forever begin
      @(negedge clk);
      #4;
      if (rst_n) begin
        case (lane_oe)
          12'h000: cur_p = 0;
          12'hFFF: cur_p = 1;
          12'hFF0: cur_p = 2;
          12'h0FF: cur_p = 3;
          default: cur_p = 9;
        endcase
        if (cur_p == 9 || (cur_p != 0 && prev_p != 0 && cur_p != prev_p))
          mon_viol++;
        prev_p = cur_p;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] w;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset lanes off", 12'h000, 12'h000);
    rst_n = 1'b1;
    tick();
    // R1: held result is zero: read it wide
    set_read(1, 0, 1, 0, 1, 0);
    tick();
    check("R1 reset result zero", 12'hFFF, 12'h000);
    set_read(0, 0, 1, 0, 1, 0);
    tick();

    // exhaustive sweep over every result word
    for (int i = 0; i < 4096; i++) begin
      w = 12'(i);
      load_word(w);
      set_read(1, 0, 1, 0, 1, 0);
      check("R7 off before edge", 12'h000, 12'h000);
      tick();
      check("R3 wide word", 12'hFFF, w);
      set_read(1, 0, 1, 0, 0, 0);
      check("R6 dark on request", 12'h000, 12'h000);
      tick();
      check("R6 dark gap cycle", 12'h000, 12'h000);
      tick();
      check("R4 upper byte", 12'hFF0, exp_hi(w));
      set_read(1, 0, 1, 0, 0, 1);
      check("R6 dark on byte swap", 12'h000, 12'h000);
      tick();
      check("R6 dark gap on swap", 12'h000, 12'h000);
      tick();
      check("R5 lower byte", 12'h0FF, exp_lo(w));
      set_read(0, 0, 1, 0, 0, 1);
      check("R2 rd_cnv drop immediate", 12'h000, 12'h000);
      tick();
    end

    // R3: byte_addr ignored in wide mode, no gap
    load_word(12'hA5C);
    set_read(1, 0, 1, 0, 1, 0);
    tick();
    for (int k = 0; k < 6; k++) begin
      byte_addr = ~byte_addr;
      #1;
      check("R3 addr ignored now", 12'hFFF, 12'hA5C);
      tick();
      check("R3 addr ignored after edge", 12'hFFF, 12'hA5C);
    end

    // R8: conv_word changes without strobe do not reach lanes
    conv_word = 12'h3C3;
    tick();
    check("R8 no load without strobe", 12'hFFF, 12'hA5C);
    conv_word = 12'h111;
    tick();
    check("R8 still held", 12'hFFF, 12'hA5C);

    // R2: each qualifier alone blocks the read
    set_read(1, 1, 1, 0, 0, 0);
    tick(); tick();
    check("R2 busy blocks", 12'h000, 12'h000);
    set_read(1, 0, 0, 0, 0, 0);
    tick(); tick();
    check("R2 chip_en low blocks", 12'h000, 12'h000);
    set_read(1, 0, 1, 1, 0, 0);
    tick(); tick();
    check("R2 chip_sel_n high blocks", 12'h000, 12'h000);
    set_read(0, 0, 1, 0, 0, 0);
    tick(); tick();
    check("R2 rd_cnv low blocks", 12'h000, 12'h000);

    // R7: from off, upper byte appears after one edge
    set_read(1, 0, 1, 0, 0, 0);
    check("R7 upper not before edge", 12'h000, 12'h000);
    tick();
    check("R7 upper after one edge", 12'hFF0, exp_hi(12'hA5C));
    // busy rises mid-read: dark at once
    busy = 1'b1;
    #1;
    check("R2 busy rise immediate", 12'h000, 12'h000);
    busy = 1'b0;
    #1;
    tick();
    // R8: strobe while reading updates next cycle
    conv_word = 12'h7E1; conv_done = 1'b1;
    tick();
    conv_done = 1'b0;
    check("R8 load while reading", 12'hFF0, exp_hi(12'h7E1));

    // rapid byte_addr toggling in narrow mode: never a byte without a gap
    for (int k = 0; k < 20; k++) begin
      byte_addr = k[0] ^ k[2];
      #1;
      tick();
    end
    set_read(0, 0, 1, 0, 0, 0);
    tick();

    tests++;
    if (mon_viol != 0) begin
      fails++;
      $display("FAIL R6 monitor: pattern violations=%0d expected=0", mon_viol);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule